// File: doc/BRIEF.md
# Configuration Readback Serializer

This block sends the contents of a configuration memory out as one serial bit stream. A rising edge on the trigger input starts it. The stream is framed in a fixed way. It opens with a header of high dummy bits. Each frame word read from memory is wrapped in a low start bit and a run of high check bits. The stream closes with a trailing start bit and an 11-bit CRC signature. A read-in-progress flag is high for as long as the stream runs.

Frame words come from a synchronous memory port with one cycle of read latency. The port is addressed by frame index. Two mode inputs change the stream:
- With capture on, the trigger edge latches the inverted value of a small group of live signals. The latched values replace a fixed window of bit positions in one frame.
- With abort on, a falling trigger edge ends a running stream at once and re-arms the block.

Top module: `rb_serializer`

## Requirements
- R1: The trigger input is sampled on rising edges of `rb_clk`. The first edge that sees it high, after an edge that saw it low, sets `rip_o` high on that same edge. A rising trigger edge while `rip_o` is high is ignored, and the stream continues unchanged.
- R2: The edge after `rip_o` rises presents the first stream bit on `dout_o`, and each later edge presents the next bit. The stream starts with 5 high header bits, followed by the low start bit of frame 0.
- R3: Each frame is one low start bit, then the `FB` data bits of the stored word, then 4 high check bits. Data bits go out least significant bit first and without inversion. Frames go out in address order, 0 to `NF-1`.
- R4: The first two data bits (bits 0 and 1) of frame 0 are always sent high, whatever is stored there.
- R5: The last seven data bits (bits `FB-7` to `FB-1`) of frame `NF-1` are always sent high.
- R6: After the last check bit of the last frame, one low start bit goes out, then the 11-bit CRC, most significant bit first. `rip_o` falls on the edge after the one that presents the last CRC bit.
- R7: The CRC uses generator x^11+x^9+x^8+x^7+x^2+1 in shift-left form, with a zero seed. Each bit b updates it as `fb = crc[10]^b; crc = (crc<<1) ^ (fb ? 0x385 : 0)`. It covers every bit sent after the first start bit, up to and including the last check bit. The header, the first start bit, the trailing start bit and the signature are not covered.
- R8: With `cap_en_i` high, data bits `CAP_OFS+k` of frame `CAP_FRAME` (k = 0..`CAP_W-1`) carry `~live_i[k]` as it was sampled on the edge where the trigger was detected. Later changes to `live_i` have no effect. With `cap_en_i` low, those positions carry the stored data.
- R9: With `abort_en_i` high, an edge that sees the trigger low after an edge that saw it high ends a running stream. On that edge `rip_o` goes low and `dout_o` goes high, and the next rising trigger edge starts a complete new stream.
- R10: While no stream runs, `dout_o` is high and `mem_rd_o` is low. `mem_rd_o` is high for one cycle, with `mem_addr_o` equal to the frame index, during the cycle before each frame's start bit appears.
- R11: With `abort_en_i` low, a falling trigger edge during a stream has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rb_clk | input | 1 | Readback clock; all state changes on its rising edge |
| rb_rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Readback trigger, edge-detected in `rb_clk` domain |
| cap_en_i | input | 1 | Capture mode enable |
| abort_en_i | input | 1 | Abort-on-falling-trigger enable |
| live_i | input | CAP_W | Live signals sampled (inverted) at trigger |
| mem_rd_o | output | 1 | Frame memory read strobe |
| mem_addr_o | output | FR_W | Frame index being read |
| mem_data_i | input | FB | Frame word, valid the cycle after the strobe |
| dout_o | output | 1 | Serial readback data |
| rip_o | output | 1 | Readback in progress |

## Verification
The stream is driven with three memory patterns: mixed, all-zero and all-one words. The all-zero pattern exposes the forced-high positions of the first and last frames and the high check bits. The all-one pattern exposes every low start bit. The mixed pattern catches bit-order, frame-order and CRC tap errors. Capture runs twice with the same live values, once enabled and once disabled, and the live inputs are changed after the trigger, which separates latching from plain pass-through. Trigger toggles in mid-stream are run with abort off and then with abort on, so that an ignored edge can be told apart from a real abort and a re-arm.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_FSTART,
        ST_DATA,
        ST_CHECK,
        ST_TSTART,
        ST_SIG,
        ST_DRAIN
    } rb_state_e;

    localparam int HEAD_BITS   = 5;
    localparam int CHECK_BITS  = 4;
    localparam int CRC_W       = 11;
    localparam int LEAD_FORCE  = 2;
    localparam int TAIL_FORCE  = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 11'h385;

endpackage

// File: rtl/rb_trig_edge.sv
module rb_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o,
    output logic fall_o
);
    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_i;
        rise_o = trig_i & ~trig_q;
        fall_o = ~trig_i & trig_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end
endmodule

// File: rtl/rb_crc_step.sv
module rb_crc_step #(
    parameter int                 W    = 11,
    parameter logic [W-1:0]       POLY = 11'h385
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end
endmodule

// File: rtl/rb_frame_bit.sv
module rb_frame_bit #(
    parameter int NF        = 4,
    parameter int FB        = 16,
    parameter int CAP_W     = 4,
    parameter int CAP_FRAME = 1,
    parameter int CAP_OFS   = 4,
    parameter int FR_W      = 2,
    parameter int IDX_W     = 5
) (
    input  logic [FR_W-1:0]  frame_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             raw_i,
    input  logic             cap_en_i,
    input  logic [CAP_W-1:0] cap_i,
    output logic             bit_o
);
    import rb_pkg::*;

    logic in_cap, cap_val, lead_force, tail_force;

    always_comb begin
        in_cap  = 1'b0;
        cap_val = 1'b0;
        for (int k = 0; k < CAP_W; k++) begin
            if (idx_i == IDX_W'(CAP_OFS + k)) begin
                in_cap  = (frame_i == FR_W'(CAP_FRAME));
                cap_val = cap_i[k];
            end
        end
        lead_force = (frame_i == '0) && (idx_i < IDX_W'(LEAD_FORCE));
        tail_force = (frame_i == FR_W'(NF - 1)) && (idx_i >= IDX_W'(FB - TAIL_FORCE));
        if (lead_force || tail_force) bit_o = 1'b1;
        else if (in_cap && cap_en_i)  bit_o = cap_val;
        else                          bit_o = raw_i;
    end
endmodule

// File: rtl/rb_serializer.sv
module rb_serializer #(
    parameter int NF        = 4,
    parameter int FB        = 16,
    parameter int CAP_W     = 4,
    parameter int CAP_FRAME = 1,
    parameter int CAP_OFS   = 4,
    parameter int FR_W      = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic             rb_clk,
    input  logic             rb_rst_n,
    input  logic             trig_i,
    input  logic             cap_en_i,
    input  logic             abort_en_i,
    input  logic [CAP_W-1:0] live_i,
    output logic             mem_rd_o,
    output logic [FR_W-1:0]  mem_addr_o,
    input  logic [FB-1:0]    mem_data_i,
    output logic             dout_o,
    output logic             rip_o
);
    import rb_pkg::*;

    localparam int IDX_MAX = (FB > CRC_W) ? FB : CRC_W;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);

    typedef struct packed {
        rb_state_e        st;
        logic [FR_W-1:0]  frame;
        logic [IDX_W-1:0] idx;
        logic [FB-1:0]    word;
        logic [CRC_W-1:0] crc;
        logic [CAP_W-1:0] cap;
        logic             dout;
    } regs_t;

    regs_t s_d, s_q;
    logic  trig_rise, trig_fall;
    logic  raw_bit, data_bit, crc_bit;
    logic  [CRC_W-1:0] crc_nxt;

    rb_trig_edge u_edge (
        .clk    (rb_clk),
        .rst_n  (rb_rst_n),
        .trig_i (trig_i),
        .rise_o (trig_rise),
        .fall_o (trig_fall)
    );

    assign raw_bit = (s_q.idx == '0) ? mem_data_i[0] : s_q.word[0];

    rb_frame_bit #(
        .NF(NF), .FB(FB), .CAP_W(CAP_W), .CAP_FRAME(CAP_FRAME),
        .CAP_OFS(CAP_OFS), .FR_W(FR_W), .IDX_W(IDX_W)
    ) u_bit (
        .frame_i  (s_q.frame),
        .idx_i    (s_q.idx),
        .raw_i    (raw_bit),
        .cap_en_i (cap_en_i),
        .cap_i    (s_q.cap),
        .bit_o    (data_bit)
    );

    // bit fed to the signature: start bits of later frames, data and checks
    always_comb begin
        case (s_q.st)
            ST_DATA:  crc_bit = data_bit;
            ST_CHECK: crc_bit = 1'b1;
            default:  crc_bit = 1'b0;
        endcase
    end

    rb_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (s_q.crc),
        .bit_i (crc_bit),
        .crc_o (crc_nxt)
    );

    always_comb begin
        s_d        = s_q;
        s_d.dout   = 1'b1;
        mem_rd_o   = 1'b0;
        mem_addr_o = s_q.frame;
        if (abort_en_i && trig_fall && s_q.st != ST_IDLE) begin
            s_d.st = ST_IDLE;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    if (trig_rise) begin
                        s_d.st    = ST_HEAD;
                        s_d.idx   = '0;
                        s_d.frame = '0;
                        s_d.crc   = '0;
                        s_d.cap   = ~live_i;
                    end
                end
                ST_HEAD: begin
                    if (s_q.idx == IDX_W'(HEAD_BITS - 1)) begin
                        s_d.st  = ST_FSTART;
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                ST_FSTART: begin
                    s_d.dout = 1'b0;
                    mem_rd_o = 1'b1;
                    if (s_q.frame != '0) s_d.crc = crc_nxt;
                    s_d.st  = ST_DATA;
                    s_d.idx = '0;
                end
                ST_DATA: begin
                    s_d.dout = data_bit;
                    s_d.crc  = crc_nxt;
                    s_d.word = ((s_q.idx == '0) ? mem_data_i : s_q.word) >> 1;
                    if (s_q.idx == IDX_W'(FB - 1)) begin
                        s_d.st  = ST_CHECK;
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                ST_CHECK: begin
                    s_d.crc = crc_nxt;
                    if (s_q.idx == IDX_W'(CHECK_BITS - 1)) begin
                        s_d.idx = '0;
                        if (s_q.frame == FR_W'(NF - 1)) begin
                            s_d.st = ST_TSTART;
                        end else begin
                            s_d.st    = ST_FSTART;
                            s_d.frame = s_q.frame + 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                ST_TSTART: begin
                    s_d.dout = 1'b0;
                    s_d.st   = ST_SIG;
                    s_d.idx  = '0;
                end
                ST_SIG: begin
                    s_d.dout = s_q.crc[CRC_W-1];
                    s_d.crc  = {s_q.crc[CRC_W-2:0], 1'b0};
                    if (s_q.idx == IDX_W'(CRC_W - 1)) s_d.st = ST_DRAIN;
                    else                              s_d.idx = s_q.idx + 1'b1;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge rb_clk or negedge rb_rst_n) begin
        if (!rb_rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.dout <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout_o = s_q.dout;
    assign rip_o  = (s_q.st != ST_IDLE);
endmodule

// File: rtl/rb_serializer_chk.sv
module rb_serializer_chk (
    input logic rb_clk,
    input logic rb_rst_n,
    input logic trig_i,
    input logic abort_en_i,
    input logic mem_rd_o,
    input logic dout_o,
    input logic rip_o
);
    logic       trg_prev;
    logic [7:0] bit_cnt;

    always_ff @(posedge rb_clk or negedge rb_rst_n) begin
        if (!rb_rst_n) begin
            trg_prev <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            trg_prev <= trig_i;
            if (!rip_o)               bit_cnt <= '0;
            else if (bit_cnt != 8'hFF) bit_cnt <= bit_cnt + 8'd1;
        end
    end

    AST_RIP_ON_TRIGGER: assert property (@(posedge rb_clk) disable iff (!rb_rst_n)
        (!rip_o && trig_i && !trg_prev) |=> rip_o); // R1

    AST_HEADER_HIGH: assert property (@(posedge rb_clk) disable iff (!rb_rst_n)
        (rip_o && bit_cnt >= 8'd1 && bit_cnt <= 8'd5) |-> dout_o); // R2

    AST_FIRST_START_LOW: assert property (@(posedge rb_clk) disable iff (!rb_rst_n)
        (rip_o && bit_cnt == 8'd6) |-> !dout_o); // R2

    AST_ABORT_ENDS: assert property (@(posedge rb_clk) disable iff (!rb_rst_n)
        (abort_en_i && rip_o && !trig_i && trg_prev) |=> (!rip_o && dout_o)); // R9

    AST_IDLE_LINE_HIGH: assert property (@(posedge rb_clk) disable iff (!rb_rst_n)
        !rip_o |-> (dout_o && !mem_rd_o)); // R10

    AST_READ_SINGLE: assert property (@(posedge rb_clk) disable iff (!rb_rst_n)
        mem_rd_o |=> !mem_rd_o); // R10
endmodule

bind rb_serializer rb_serializer_chk u_chk (
    .rb_clk     (rb_clk),
    .rb_rst_n   (rb_rst_n),
    .trig_i     (trig_i),
    .abort_en_i (abort_en_i),
    .mem_rd_o   (mem_rd_o),
    .dout_o     (dout_o),
    .rip_o      (rip_o)
);

// File: tb/rb_serializer_tb_top.sv
`timescale 1ns/1ps
module rb_serializer_tb_top;
    localparam int NF = 4, FB = 16, CAP_W = 4, CAP_FRAME = 1, CAP_OFS = 4;
    localparam int FR_W = 2;
    localparam int SLEN = 5 + NF * (1 + FB + 4) + 1 + 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig = 1'b0, cap_en = 1'b0, abort_en = 1'b0;
    logic [CAP_W-1:0] live = '0;
    logic             mem_rd, dout, rip;
    logic [FR_W-1:0]  mem_addr;
    logic [FB-1:0]    mem_q = '0;
    logic [FB-1:0]    mem_words [NF];

    int    n_chk = 0, n_bad = 0;
    logic  exp_bit [SLEN];
    string exp_tag [SLEN];

    always #5 clk = ~clk;

    always_ff @(posedge clk) if (mem_rd) mem_q <= mem_words[mem_addr];

    rb_serializer #(.NF(NF), .FB(FB), .CAP_W(CAP_W), .CAP_FRAME(CAP_FRAME),
                    .CAP_OFS(CAP_OFS)) dut_i (
        .rb_clk(clk), .rb_rst_n(rst_n), .trig_i(trig), .cap_en_i(cap_en),
        .abort_en_i(abort_en), .live_i(live), .mem_rd_o(mem_rd),
        .mem_addr_o(mem_addr), .mem_data_i(mem_q), .dout_o(dout), .rip_o(rip));

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // R3 R4 R5 R7 R8: expected stream computed from the requirements
    function automatic void build_exp(logic cap, logic [CAP_W-1:0] lv);
        int p = 0;
        logic [10:0] crc = '0;
        logic b, fb;
        for (int h = 0; h < 5; h++) begin exp_bit[p] = 1'b1; exp_tag[p] = "R2 header"; p++; end
        for (int f = 0; f < NF; f++) begin
            exp_bit[p] = 1'b0; exp_tag[p] = (f == 0) ? "R2 first start" : "R3 start";
            if (f != 0) begin fb = crc[10]; crc = {crc[9:0], 1'b0} ^ (fb ? 11'h385 : 11'h0); end
            p++;
            for (int i = 0; i < FB; i++) begin
                b = mem_words[f][i];
                exp_tag[p] = "R3 data";
                if (cap && f == CAP_FRAME && i >= CAP_OFS && i < CAP_OFS + CAP_W) begin
                    b = ~lv[i - CAP_OFS]; exp_tag[p] = "R8 capture";
                end
                if (f == 0 && i < 2)       begin b = 1'b1; exp_tag[p] = "R4 lead"; end
                if (f == NF-1 && i >= FB-7) begin b = 1'b1; exp_tag[p] = "R5 tail"; end
                exp_bit[p] = b; p++;
                fb = crc[10] ^ b; crc = {crc[9:0], 1'b0} ^ (fb ? 11'h385 : 11'h0);
            end
            for (int c = 0; c < 4; c++) begin
                exp_bit[p] = 1'b1; exp_tag[p] = "R3 check"; p++;
                fb = crc[10] ^ 1'b1; crc = {crc[9:0], 1'b0} ^ (fb ? 11'h385 : 11'h0);
            end
        end
        exp_bit[p] = 1'b0; exp_tag[p] = "R6 trailing start"; p++;
        for (int s = 10; s >= 0; s--) begin exp_bit[p] = crc[s]; exp_tag[p] = "R7 crc"; p++; end
    endfunction

    // full stream; if toggle, trigger drops at bit 20 and rises at bit 30 (R1 R11)
    task automatic run_stream(logic cap, logic [CAP_W-1:0] lv, logic toggle);
        build_exp(cap, lv);
        @(negedge clk); live = lv; cap_en = cap; trig = 1'b1;
        @(negedge clk); check("R1 rip rises", rip, 1'b1); live = ~lv;
        for (int k = 0; k < SLEN; k++) begin
            @(negedge clk);
            check(exp_tag[k], dout, exp_bit[k]);
            if (toggle && k == 20) trig = 1'b0;
            if (toggle && k == 30) trig = 1'b1;
        end
        @(negedge clk);
        check("R6 rip falls", rip, 1'b0);
        check("R10 idle high", dout, 1'b1);
        trig = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        check("R10 reset rip", rip, 1'b0);
        check("R10 reset dout", dout, 1'b1);
        check("R10 reset read", mem_rd, 1'b0);
    endtask

    task automatic test_patterns();
        mem_words[0] = 16'hA5C3; mem_words[1] = 16'h3C96;
        mem_words[2] = 16'h0F1E; mem_words[3] = 16'h7B24;
        run_stream(1'b0, 4'h0, 1'b0);
        for (int f = 0; f < NF; f++) mem_words[f] = 16'h0000;
        run_stream(1'b0, 4'h0, 1'b0);
        for (int f = 0; f < NF; f++) mem_words[f] = 16'hFFFF;
        run_stream(1'b0, 4'h0, 1'b0);
    endtask

    task automatic test_capture();
        mem_words[0] = 16'h1234; mem_words[1] = 16'h00F0;
        mem_words[2] = 16'h5555; mem_words[3] = 16'h8001;
        run_stream(1'b1, 4'b1010, 1'b0);
        run_stream(1'b0, 4'b1010, 1'b0);
        run_stream(1'b1, 4'b0011, 1'b0);
    endtask

    task automatic test_retrigger();
        abort_en = 1'b0;
        mem_words[0] = 16'hC0DE; mem_words[1] = 16'hBEEF;
        mem_words[2] = 16'h1357; mem_words[3] = 16'h2468;
        run_stream(1'b0, 4'h0, 1'b1);
    endtask

    task automatic test_abort();
        abort_en = 1'b1;
        build_exp(1'b0, 4'h0);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); check("R9 rip before abort", rip, 1'b1);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); check(exp_tag[k], dout, exp_bit[k]);
        end
        trig = 1'b0;
        @(negedge clk);
        check("R9 abort rip low", rip, 1'b0);
        check("R9 abort dout high", dout, 1'b1);
        repeat (4) @(negedge clk);
        check("R9 stays idle", rip, 1'b0);
        run_stream(1'b0, 4'h0, 1'b0);   // R9 re-armed: full stream again
        abort_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int f = 0; f < NF; f++) mem_words[f] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_patterns();
        test_capture();
        test_retrigger();
        test_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule